// File: doc/BRIEF.md
# Keccak Round Sequencer (plain and two-share)

This block is the control side of a permutation engine that evaluates one Keccak-f round per pass through a shared datapath. A single-cycle start request begins a run. The sequencer then steps through every round of the permutation. For each round it tells the datapath which round constant to use, which step of the round is active, whether the nonlinear half is selected, when fresh masking randomness must be supplied, and when the state register should take the datapath result.

The number of rounds follows from the state width. The lane width is the state width divided by 25, and the round count is twelve plus twice the base-2 log of the lane width. The default 1600-bit state therefore has 24 rounds. With `MASKED` = 0 a whole round completes in one clock, so the round index moves on every cycle. With `MASKED` = 1 each round takes four cycles. The first cycle runs the linear steps, and the other three run the shared nonlinear step in two lane-half passes. One auxiliary random bit, taken while the linear step is selected, picks which lane half goes first. That bit stays fixed for the rest of the round. Masked operation needs a state of at least 50 bits.

Top module: `ksq_round_seq`

## Requirements
- R1: The round index `rnd_o` takes the values 0 to N-1 in increasing order, where N = 12 + 2*log2(STATE_W/25). For STATE_W = 1600, N = 24. For STATE_W = 200, N = 18.
- R2: A start request while idle makes `busy_o` high on the next cycle, with `rnd_o` = 0 and `cycle_o` = 0. A start request while busy has no effect on the index sequence.
- R3: In masked mode each round shows `cycle_o` = 0, 1, 2, 3 on consecutive cycles, and `rnd_o` advances after cycle 3. In plain mode `cycle_o` stays 0 and `rnd_o` advances every busy cycle.
- R4: `phase_sel_o` is low in cycle 0 and high in cycles 1 to 3. It is low while idle and always low in plain mode. Once it rises it stays high for at least the next cycle.
- R5: `rand_req_o` is high only in masked cycles 1 and 2. It is never high in cycle 0, in cycle 3, while idle, or in plain mode.
- R6: In masked mode `state_we_o` is high in cycles 0, 2 and 3 and low in cycle 1. In plain mode it is high on every busy cycle. It is low while idle.
- R7: On every clock edge where `phase_sel_o` is low, `low_first_o` loads `rand_aux_i`. On every edge where `phase_sel_o` is high, `low_first_o` holds. In cycles 1 to 3 it therefore equals the `rand_aux_i` value present in cycle 0 of the same round.
- R8: `done_o` is high for exactly one cycle: the cycle after the last cycle of the final round. In that cycle `busy_o` is already low.
- R9: Asynchronous active-low reset clears `busy_o`, `done_o`, `rnd_o`, `cycle_o` and `low_first_o` to 0. This holds even in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; acted on only while idle |
| rand_aux_i | input | 1 | Random bit choosing the lane-half order |
| rnd_o | output | RND_W | Current round index |
| cycle_o | output | 2 | Step within the round (always 0 in plain mode) |
| phase_sel_o | output | 1 | High when the nonlinear half is selected |
| rand_req_o | output | 1 | Fresh masking randomness needed this cycle |
| state_we_o | output | 1 | State register write enable |
| low_first_o | output | 1 | Captured lane-half order for the round |
| busy_o | output | 1 | Permutation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A corrupted step counter shows within one cycle. `phase_sel_o`, `rand_req_o` and `state_we_o` then disagree with the fixed four-entry schedule, and a missed wrap shifts `rnd_o` at the next round boundary. A wrong round limit moves `done_o` earlier or later than cycle 97 of a masked 1600-bit run, or cycle 19 of a plain 200-bit run. A lost hold on the order bit appears at `low_first_o` in cycles 2 or 3 of the first affected round, because the bench drives the opposite value on `rand_aux_i` during those cycles.

// File: rtl/ksq_pkg.sv
package ksq_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_e;

  localparam int CYC_W = 2;

  function automatic int round_count(input int state_w);
    return 12 + 2 * $clog2(state_w / 25);
  endfunction
endpackage

// File: rtl/ksq_cycle_ctr.sv
module ksq_cycle_ctr
  import ksq_pkg::*;
#(
  parameter bit MASKED = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  output logic [CYC_W-1:0] cyc_o,
  output logic             wrap_o
);
  logic [CYC_W-1:0] cyc_q, cyc_nxt;

  if (MASKED) begin : g_four_step
    assign cyc_nxt = cyc_q + 1'b1;
    assign wrap_o  = (cyc_q == '1);
  end else begin : g_one_step
    assign cyc_nxt = '0;
    assign wrap_o  = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cyc_q <= '0;
    else if (load_i)  cyc_q <= '0;
    else if (run_i)   cyc_q <= cyc_nxt;
  end

  assign cyc_o = cyc_q;
endmodule

// File: rtl/ksq_round_ctr.sv
module ksq_round_ctr #(
  parameter int NUM_RND = 24,
  parameter int RND_W   = $clog2(NUM_RND + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  output logic [RND_W-1:0] rnd_o,
  output logic             last_o
);
  localparam logic [RND_W-1:0] LastIdx = RND_W'(NUM_RND - 1);

  logic [RND_W-1:0] rnd_q;

  assign last_o = (rnd_q == LastIdx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rnd_q <= '0;
    else if (load_i)  rnd_q <= '0;
    else if (step_i)  rnd_q <= last_o ? '0 : rnd_q + 1'b1;
  end

  assign rnd_o = rnd_q;
endmodule

// File: rtl/ksq_order_reg.sv
module ksq_order_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic aux_i,
  output logic order_o
);
  logic order_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         order_q <= 1'b0;
    else if (capture_i)  order_q <= aux_i;
  end

  assign order_o = order_q;
endmodule

// File: rtl/ksq_phase_dec.sv
module ksq_phase_dec
  import ksq_pkg::*;
(
  input  logic             busy_i,
  input  logic [CYC_W-1:0] cyc_i,
  output logic             phase_sel_o,
  output logic             rand_req_o,
  output logic             state_we_o
);
  // cycle 0: linear steps; 1: first half chi; 2: 2nd half chi + 1st out; 3: 2nd out
  always_comb begin
    phase_sel_o = busy_i && (cyc_i != 2'd0);
    rand_req_o  = busy_i && ((cyc_i == 2'd1) || (cyc_i == 2'd2));
    state_we_o  = busy_i && (cyc_i != 2'd1);
  end
endmodule

// File: rtl/ksq_round_seq.sv
module ksq_round_seq
  import ksq_pkg::*;
#(
  parameter int STATE_W = 1600,
  parameter bit MASKED  = 1'b1,
  localparam int NUM_RND = 12 + 2 * $clog2(STATE_W / 25),
  localparam int RND_W   = $clog2(NUM_RND + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rand_aux_i,
  output logic [RND_W-1:0] rnd_o,
  output logic [1:0]       cycle_o,
  output logic             phase_sel_o,
  output logic             rand_req_o,
  output logic             state_we_o,
  output logic             low_first_o,
  output logic             busy_o,
  output logic             done_o
);
  seq_state_e state_q, state_d;
  logic       done_q;
  logic       start_acc, cyc_wrap, rnd_last, finish;
  logic       busy;

  assign busy      = (state_q == SEQ_RUN);
  assign start_acc = !busy && start_i;
  assign finish    = busy && cyc_wrap && rnd_last;

  always_comb begin
    state_d = state_q;
    if (start_acc)   state_d = SEQ_RUN;
    else if (finish) state_d = SEQ_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
    end
  end

  ksq_cycle_ctr #(.MASKED(MASKED)) u_cyc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_acc),
    .run_i  (busy),
    .cyc_o  (cycle_o),
    .wrap_o (cyc_wrap)
  );

  ksq_round_ctr #(.NUM_RND(NUM_RND), .RND_W(RND_W)) u_rnd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_acc),
    .step_i (busy && cyc_wrap),
    .rnd_o  (rnd_o),
    .last_o (rnd_last)
  );

  ksq_phase_dec u_dec (
    .busy_i      (busy),
    .cyc_i       (cycle_o),
    .phase_sel_o (phase_sel_o),
    .rand_req_o  (rand_req_o),
    .state_we_o  (state_we_o)
  );

  ksq_order_reg u_ord (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (!phase_sel_o),
    .aux_i     (rand_aux_i),
    .order_o   (low_first_o)
  );

  assign busy_o = busy;
  assign done_o = done_q;
endmodule

// File: rtl/ksq_round_seq_chk.sv
module ksq_round_seq_chk #(
  parameter int STATE_W = 1600,
  parameter bit MASKED  = 1'b1,
  localparam int NUM_RND = 12 + 2 * $clog2(STATE_W / 25),
  localparam int RND_W   = $clog2(NUM_RND + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [RND_W-1:0] rnd_o,
  input logic [1:0]       cycle_o,
  input logic             phase_sel_o,
  input logic             rand_req_o,
  input logic             state_we_o,
  input logic             low_first_o,
  input logic             busy_o,
  input logic             done_o
);
  p_rnd_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (rnd_o < RND_W'(NUM_RND)));

  p_start_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && rnd_o == '0 && cycle_o == 2'd0));

  p_rand_mid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rand_req_o |-> (busy_o && (cycle_o == 2'd1 || cycle_o == 2'd2)));

  p_order_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(phase_sel_o) |-> $stable(low_first_o));

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!state_we_o && !phase_sel_o));

  if (MASKED) begin : g_masked
    p_cycle_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && cycle_o != 2'd3) |=> (cycle_o == 2'($past(cycle_o) + 2'd1)));

    p_phase_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(phase_sel_o) |=> phase_sel_o);

    p_we_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && cycle_o == 2'd1) |-> !state_we_o);
  end else begin : g_plain
    p_plain_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> (cycle_o == 2'd0 && state_we_o));

    p_plain_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> (!phase_sel_o && !rand_req_o));
  end
endmodule

bind ksq_round_seq ksq_round_seq_chk #(.STATE_W(STATE_W), .MASKED(MASKED)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .rnd_o       (rnd_o),
  .cycle_o     (cycle_o),
  .phase_sel_o (phase_sel_o),
  .rand_req_o  (rand_req_o),
  .state_we_o  (state_we_o),
  .low_first_o (low_first_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/ksq_round_seq_tb_top.sv
module ksq_round_seq_tb_top;
  localparam int M_RND = 24;
  localparam int U_RND = 18;
  // per step: {phase_sel, rand_req, state_we}
  localparam logic [2:0] SCHED [4] = '{3'b001, 3'b110, 3'b111, 3'b101};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_start = 1'b0, u_start = 1'b0, m_aux = 1'b0;
  int   checks = 0, failures = 0;
  bit   finished = 1'b0;

  logic [4:0] m_rnd, u_rnd;
  logic [1:0] m_cyc, u_cyc;
  logic m_ph, m_req, m_we, m_low, m_busy, m_done;
  logic u_ph, u_req, u_we, u_low, u_busy, u_done;

  always #5 clk = ~clk;

  ksq_round_seq #(.STATE_W(1600), .MASKED(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(m_start), .rand_aux_i(m_aux),
    .rnd_o(m_rnd), .cycle_o(m_cyc), .phase_sel_o(m_ph), .rand_req_o(m_req),
    .state_we_o(m_we), .low_first_o(m_low), .busy_o(m_busy), .done_o(m_done));

  ksq_round_seq #(.STATE_W(200), .MASKED(1'b0)) dut_u (
    .clk_i(clk), .rst_ni(rst_n), .start_i(u_start), .rand_aux_i(1'b0),
    .rnd_o(u_rnd), .cycle_o(u_cyc), .phase_sel_o(u_ph), .rand_req_o(u_req),
    .state_we_o(u_we), .low_first_o(u_low), .busy_o(u_busy), .done_o(u_done));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic aux_bit(input int r);
    return logic'(r[0] ^ r[2] ^ r[3]);
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 busy", m_busy, 0); chk("R9 done", m_done, 0);
    chk("R9 rnd", m_rnd, 0);   chk("R9 cyc", m_cyc, 0);
    chk("R9 low", m_low, 0);   chk("R9 u_busy", u_busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 idle we", m_we, 0); chk("R5 idle req", m_req, 0);
    chk("R4 idle ph", m_ph, 0);

    // masked full run
    m_start = 1'b1;
    @(negedge clk);
    m_start = 1'b0;
    chk("R2 busy", m_busy, 1); chk("R2 rnd", m_rnd, 0); chk("R2 cyc", m_cyc, 0);
    for (int r = 0; r < M_RND; r++) begin
      for (int c = 0; c < 4; c++) begin
        chk("R1 rnd", m_rnd, r);
        chk("R3 cyc", m_cyc, c);
        chk("R4 phase", m_ph, SCHED[c][2]);
        chk("R5 randreq", m_req, SCHED[c][1]);
        chk("R6 we", m_we, SCHED[c][0]);
        chk("R8 no early done", m_done, 0);
        if (c != 0) chk("R7 order", m_low, aux_bit(r));
        // cycle 0 drives the round's bit, later cycles drive the opposite
        m_aux = (c == 0) ? aux_bit(r) : ~aux_bit(r);
        m_start = (r == 5 && c == 2);   // R2 start while busy ignored
        @(negedge clk);
      end
    end
    m_start = 1'b0;
    chk("R8 done", m_done, 1); chk("R8 busy low", m_busy, 0);
    @(negedge clk);
    chk("R8 done pulse", m_done, 0);

    // plain run
    u_start = 1'b1;
    @(negedge clk);
    u_start = 1'b0;
    for (int r = 0; r < U_RND; r++) begin
      chk("R1 u_rnd", u_rnd, r);
      chk("R3 u_cyc", u_cyc, 0);
      chk("R4 u_phase", u_ph, 0);
      chk("R5 u_req", u_req, 0);
      chk("R6 u_we", u_we, 1);
      chk("R8 u_no_done", u_done, 0);
      @(negedge clk);
    end
    chk("R8 u_done", u_done, 1); chk("R8 u_busy", u_busy, 0);
    @(negedge clk);
    chk("R8 u_done pulse", u_done, 0);

    // R9 reset mid-run
    m_start = 1'b1; m_aux = 1'b1;
    @(negedge clk);
    m_start = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 pre busy", m_busy, 1);
    rst_n = 1'b0;
    #1;
    chk("R9 mid busy", m_busy, 0); chk("R9 mid rnd", m_rnd, 0);
    chk("R9 mid cyc", m_cyc, 0);   chk("R9 mid low", m_low, 0);
    @(negedge clk);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule